// File: doc/BRIEF.md
# Multi-Ring DMA Control and Status Register Bank

This block is the 32-bit register file that software uses to steer a packet DMA engine with eight transmit and eight receive descriptor rings. Accesses arrive on a simple valid/write/address/data port that covers a 4 KB window. Only whole words are transferred: the low two address bits are ignored, and the word index is the byte address shifted right by two. Each register belongs to one access class: read-write, write-only, write-one-to-clear or read-only. Read data comes back on the clock edge that follows the read request.

Beyond plain storage, the bank produces the side effects that the DMA engine depends on. Writing a 1 to a ring's halt flag restarts that ring with a one-cycle kick pulse. On the receive side the kick only fires for a ring whose flag was already clear. Loading a ring's base address also loads that ring's current descriptor pointer. The engine reports events and halted rings on set inputs, and these drive three interrupt lines. A line falls only when a software clear leaves its whole event group empty.

Word map: 0x000 identity (read-only), 0x004 control (read-write), 0x008 event (write-one-to-clear), 0x00C transmit halt, 0x010 receive halt, 0x014 command (write-only). Transmit ring n uses base 0x100+8n and pointer 0x104+8n. Receive ring n uses base 0x200+8n and pointer 0x204+8n. Every other word is unmapped.

Top module: `dmareg_top`

## Requirements
- R1: After reset the identity word reads IDENT_VALUE. Every other register reads zero, and all interrupt lines and kick outputs are low.
- R2: Address bits [1:0] are ignored. A word is selected by busAddr[11:2] alone, and every write stores or clears all 32 bits at once.
- R3: A read returns its data on busRdata with busRvalid high, registered on the edge that follows the request. The write-only command word reads zero. Unmapped words read zero and ignore writes.
- R4: The identity word ignores writes. The control word stores and returns any written value.
- R5: In the transmit halt word, bit (31-i) is the halt flag of tx ring i and is set by txHaltIn[i]. Each written 1 clears that bit and pulses ringKick[i] in the cycle after the write, whatever the bit held before.
- R6: In the receive halt word, bit (23-i) is the halt flag of rx ring i and is set by rxHaltIn[i]. A written 1 pulses ringKick[8+i] only if the bit was 0 before the write. The write then clears every written bit.
- R7: A write to a ring's base word stores the value with bits [2:0] forced to 0. The same value is loaded into that ring's pointer word. The pointer word can also be written directly, and doing so leaves the base unchanged.
- R8: The event word is write-one-to-clear. hwEvent sets its defined bits: bit 0 tx frame, bit 1 rx frame, bits [23:8] error and status events. Undefined bits stay 0. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: txIrq rises in the cycle after hwEvent[0], and rxIrq in the cycle after hwEvent[1]. Each falls after an event write that leaves its own frame bit clear.
- R10: errIrq rises after any hwEvent[23:8] bit. It falls only after an event write that leaves all of bits [23:8] clear.
- R11: Kick pulses last one cycle and appear only in the cycle right after a write to a halt word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address in the 4 KB window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| busRvalid | output | 1 | busRdata holds the result of last cycle's read |
| hwEvent | input | 32 | Engine event set pulses into the event word |
| txHaltIn | input | 8 | Engine reports tx ring i halted |
| rxHaltIn | input | 8 | Engine reports rx ring i halted |
| ringKick | output | 16 | One-cycle restart pulses: [7:0] tx rings, [15:8] rx rings |
| txIrq | output | 1 | Transmit frame interrupt |
| rxIrq | output | 1 | Receive frame interrupt |
| errIrq | output | 1 | Error and status interrupt |

## Verification
The hardest case to reach from the ports is the receive halt write that covers two rings, one already halted and one not. Only the clear ring may be kicked, and both bits must read back clear. The bench first halts one ring through rxHaltIn, then writes a mask that covers it and a second, idle ring. A second write to the now-clear ring then shows that it kicks. A second hard case is a software clear and an engine set of the same event bit in the same cycle. The bench drives hwEvent and the clearing write on the same edge, then reads the word back and checks that the interrupt stayed high.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int RINGS      = 8;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int WORD_W     = ADDR_W - 2;
  localparam int RING_IDX_W = $clog2(RINGS);
  localparam int KICK_W     = 2 * RINGS;

  // fixed word indices in the low page
  localparam int IDX_IDENT  = 0;
  localparam int IDX_CTRL   = 1;
  localparam int IDX_EVENT  = 2;
  localparam int IDX_TXHALT = 3;
  localparam int IDX_RXHALT = 4;
  localparam int IDX_CMD    = 5;

  // ring banks: bank field selects tx/rx, slot field selects the ring
  localparam int BANK_LSB   = 8;
  localparam int SLOT_LSB   = 3;
  localparam int BANK_W     = ADDR_W - BANK_LSB;
  localparam int SLOT_W     = BANK_LSB - SLOT_LSB;
  localparam int TX_BANK    = 1;
  localparam int RX_BANK    = 2;
  localparam int ALIGN_BITS = 3;

  // halt flag layout: ring i sits at TOP - i
  localparam int TX_HALT_TOP = 31;
  localparam int RX_HALT_TOP = 23;

  // event word layout
  localparam int EVT_TX_BIT = 0;
  localparam int EVT_RX_BIT = 1;
  localparam int EVT_ERR_LO = 8;
  localparam int EVT_ERR_HI = 23;

  function automatic logic [DATA_W-1:0] evtMaskFn();
    logic [DATA_W-1:0] m;
    m = '0;
    m[EVT_TX_BIT] = 1'b1;
    m[EVT_RX_BIT] = 1'b1;
    for (int b = EVT_ERR_LO; b <= EVT_ERR_HI; b++) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] EVT_MASK = evtMaskFn();

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IDENT,
    SEL_CTRL,
    SEL_EVENT,
    SEL_TXHALT,
    SEL_RXHALT,
    SEL_CMD,
    SEL_TXBASE,
    SEL_TXPTR,
    SEL_RXBASE,
    SEL_RXPTR
  } rdSel_e;

  typedef struct packed {
    logic                  wrCtrl;
    logic                  wrCmd;
    logic                  wrEvent;
    logic                  wrTxHalt;
    logic                  wrRxHalt;
    logic                  wrTxBase;
    logic                  wrTxPtr;
    logic                  wrRxBase;
    logic                  wrRxPtr;
    logic [RING_IDX_W-1:0] ring;
    logic                  rdEn;
    rdSel_e                rdSel;
  } strobe_t;

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);

  logic [WORD_W-1:0] word;
  logic [BANK_W-1:0] bank;
  logic [SLOT_W-1:0] slot;
  logic              isPtr;
  logic              slotOk;
  logic              doWr;
  rdSel_e            sel;

  assign word   = busAddr[ADDR_W-1:2];
  assign bank   = busAddr[ADDR_W-1:BANK_LSB];
  assign slot   = busAddr[BANK_LSB-1:SLOT_LSB];
  assign isPtr  = busAddr[2];
  assign slotOk = ({1'b0, slot} < (SLOT_W+1)'(RINGS));
  assign doWr   = busValid & busWrite;

  always_comb begin
    sel = SEL_NONE;
    case (word)
      WORD_W'(IDX_IDENT):  sel = SEL_IDENT;
      WORD_W'(IDX_CTRL):   sel = SEL_CTRL;
      WORD_W'(IDX_EVENT):  sel = SEL_EVENT;
      WORD_W'(IDX_TXHALT): sel = SEL_TXHALT;
      WORD_W'(IDX_RXHALT): sel = SEL_RXHALT;
      WORD_W'(IDX_CMD):    sel = SEL_CMD;
      default: begin
        if (slotOk && bank == BANK_W'(TX_BANK))
          sel = isPtr ? SEL_TXPTR : SEL_TXBASE;
        else if (slotOk && bank == BANK_W'(RX_BANK))
          sel = isPtr ? SEL_RXPTR : SEL_RXBASE;
      end
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.wrCtrl   = doWr && sel == SEL_CTRL;
    strb.wrCmd    = doWr && sel == SEL_CMD;
    strb.wrEvent  = doWr && sel == SEL_EVENT;
    strb.wrTxHalt = doWr && sel == SEL_TXHALT;
    strb.wrRxHalt = doWr && sel == SEL_RXHALT;
    strb.wrTxBase = doWr && sel == SEL_TXBASE;
    strb.wrTxPtr  = doWr && sel == SEL_TXPTR;
    strb.wrRxBase = doWr && sel == SEL_RXBASE;
    strb.wrRxPtr  = doWr && sel == SEL_RXPTR;
    strb.ring     = slot[RING_IDX_W-1:0];
    strb.rdEn     = busValid & ~busWrite;
    strb.rdSel    = sel;
  end

endmodule

// File: rtl/dmareg_ring_slot.sv
module dmareg_ring_slot
  import dmareg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrBase,
  input  logic              wrPtr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] baseQ,
  output logic [DATA_W-1:0] ptrQ
);

  logic [DATA_W-1:0] aligned;
  assign aligned = {wdata[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      ptrQ  <= '0;
    end else begin
      if (wrBase) begin
        baseQ <= aligned;
        ptrQ  <= aligned;
      end else if (wrPtr) begin
        ptrQ  <= wdata;
      end
    end
  end

endmodule

// File: rtl/dmareg_datapath.sv
module dmareg_datapath
  import dmareg_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDENT_VALUE = 32'h5E7C_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] hwEvent,
  input  logic [RINGS-1:0]  txHaltIn,
  input  logic [RINGS-1:0]  rxHaltIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic [KICK_W-1:0] ringKick,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              errIrq
);

  logic [DATA_W-1:0] ctrlQ, cmdQ, eventQ, txHaltQ, rxHaltQ;
  logic [DATA_W-1:0] eventD, txHaltD, rxHaltD;
  logic [DATA_W-1:0] txSetVec, rxSetVec;
  logic [RINGS-1:0]  txKickD, rxKickD;
  logic [DATA_W-1:0] txBaseArr [RINGS];
  logic [DATA_W-1:0] txPtrArr  [RINGS];
  logic [DATA_W-1:0] rxBaseArr [RINGS];
  logic [DATA_W-1:0] rxPtrArr  [RINGS];
  logic [DATA_W-1:0] rdMux;
  logic              txIrqD, rxIrqD, errIrqD;
  logic              errSet, errLeft;

  // per-ring base/pointer pairs
  for (genvar n = 0; n < RINGS; n++) begin : g_ring
    dmareg_ring_slot u_tx (
      .clk   (clk),
      .rstN  (rstN),
      .wrBase(strb.wrTxBase && strb.ring == RING_IDX_W'(n)),
      .wrPtr (strb.wrTxPtr  && strb.ring == RING_IDX_W'(n)),
      .wdata (busWdata),
      .baseQ (txBaseArr[n]),
      .ptrQ  (txPtrArr[n])
    );
    dmareg_ring_slot u_rx (
      .clk   (clk),
      .rstN  (rstN),
      .wrBase(strb.wrRxBase && strb.ring == RING_IDX_W'(n)),
      .wrPtr (strb.wrRxPtr  && strb.ring == RING_IDX_W'(n)),
      .wdata (busWdata),
      .baseQ (rxBaseArr[n]),
      .ptrQ  (rxPtrArr[n])
    );
  end

  // halt flags: ring i lives at TOP - i
  always_comb begin
    txSetVec = '0;
    rxSetVec = '0;
    txKickD  = '0;
    rxKickD  = '0;
    for (int i = 0; i < RINGS; i++) begin
      txSetVec[TX_HALT_TOP-i] = txHaltIn[i];
      rxSetVec[RX_HALT_TOP-i] = rxHaltIn[i];
      txKickD[i] = strb.wrTxHalt & busWdata[TX_HALT_TOP-i];
      rxKickD[i] = strb.wrRxHalt & busWdata[RX_HALT_TOP-i] & ~rxHaltQ[RX_HALT_TOP-i];
    end
  end

  assign txHaltD = (txHaltQ & ~(strb.wrTxHalt ? busWdata : '0)) | txSetVec;
  assign rxHaltD = (rxHaltQ & ~(strb.wrRxHalt ? busWdata : '0)) | rxSetVec;
  assign eventD  = (eventQ  & ~(strb.wrEvent  ? busWdata : '0)) | (hwEvent & EVT_MASK);

  // interrupt lines: set by engine events, dropped by a clear that empties the group
  assign errSet  = |hwEvent[EVT_ERR_HI:EVT_ERR_LO];
  assign errLeft = |eventD[EVT_ERR_HI:EVT_ERR_LO];

  always_comb begin
    txIrqD = txIrq;
    if (hwEvent[EVT_TX_BIT])                       txIrqD = 1'b1;
    else if (strb.wrEvent && !eventD[EVT_TX_BIT])  txIrqD = 1'b0;
    rxIrqD = rxIrq;
    if (hwEvent[EVT_RX_BIT])                       rxIrqD = 1'b1;
    else if (strb.wrEvent && !eventD[EVT_RX_BIT])  rxIrqD = 1'b0;
    errIrqD = errIrq;
    if (errSet)                                    errIrqD = 1'b1;
    else if (strb.wrEvent && !errLeft)             errIrqD = 1'b0;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_IDENT:  rdMux = IDENT_VALUE;
      SEL_CTRL:   rdMux = ctrlQ;
      SEL_EVENT:  rdMux = eventQ;
      SEL_TXHALT: rdMux = txHaltQ;
      SEL_RXHALT: rdMux = rxHaltQ;
      SEL_CMD:    rdMux = '0;
      SEL_TXBASE: rdMux = txBaseArr[strb.ring];
      SEL_TXPTR:  rdMux = txPtrArr[strb.ring];
      SEL_RXBASE: rdMux = rxBaseArr[strb.ring];
      SEL_RXPTR:  rdMux = rxPtrArr[strb.ring];
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      cmdQ      <= '0;
      eventQ    <= '0;
      txHaltQ   <= '0;
      rxHaltQ   <= '0;
      ringKick  <= '0;
      txIrq     <= 1'b0;
      rxIrq     <= 1'b0;
      errIrq    <= 1'b0;
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      if (strb.wrCtrl) ctrlQ <= busWdata;
      if (strb.wrCmd)  cmdQ  <= busWdata;
      eventQ    <= eventD;
      txHaltQ   <= txHaltD;
      rxHaltQ   <= rxHaltD;
      ringKick  <= {rxKickD, txKickD};
      txIrq     <= txIrqD;
      rxIrq     <= rxIrqD;
      errIrq    <= errIrqD;
      busRvalid <= strb.rdEn;
      if (strb.rdEn) busRdata <= rdMux;
    end
  end

  // the command word is write-only: its content leaves the bank through no read path
  logic cmdUnused;
  assign cmdUnused = ^cmdQ;

endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDENT_VALUE = 32'h5E7C_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  input  logic [DATA_W-1:0] hwEvent,
  input  logic [RINGS-1:0]  txHaltIn,
  input  logic [RINGS-1:0]  rxHaltIn,
  output logic [KICK_W-1:0] ringKick,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              errIrq
);

  strobe_t strb;

  dmareg_decode u_decode (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strb    (strb)
  );

  dmareg_datapath #(.IDENT_VALUE(IDENT_VALUE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .hwEvent  (hwEvent),
    .txHaltIn (txHaltIn),
    .rxHaltIn (rxHaltIn),
    .busRdata (busRdata),
    .busRvalid(busRvalid),
    .ringKick (ringKick),
    .txIrq    (txIrq),
    .rxIrq    (rxIrq),
    .errIrq   (errIrq)
  );

endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk
  import dmareg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busRvalid,
  input logic [DATA_W-1:0] hwEvent,
  input logic [RINGS-1:0]  txHaltIn,
  input logic [RINGS-1:0]  rxHaltIn,
  input logic [KICK_W-1:0] ringKick,
  input logic              txIrq,
  input logic              rxIrq,
  input logic              errIrq
);

  logic wrEvt, wrTx, wrRx;
  assign wrEvt = busValid && busWrite && busAddr[ADDR_W-1:2] == WORD_W'(IDX_EVENT);
  assign wrTx  = busValid && busWrite && busAddr[ADDR_W-1:2] == WORD_W'(IDX_TXHALT);
  assign wrRx  = busValid && busWrite && busAddr[ADDR_W-1:2] == WORD_W'(IDX_RXHALT);

  // R3
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRvalid |-> $past(busValid && !busWrite));

  // R11
  kick_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ringKick) |-> $past(busValid && busWrite));

  // R5
  tx_kick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ringKick[RINGS-1:0]) |-> $past(wrTx));

  // R6
  rx_kick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ringKick[KICK_W-1:RINGS]) |-> $past(wrRx));

  // R9
  tx_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIrq) |-> $past(hwEvent[EVT_TX_BIT]));

  // R9
  tx_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txIrq) |-> $past(wrEvt && busWdata[EVT_TX_BIT]));

  // R9
  rx_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxIrq) |-> $past(wrEvt && busWdata[EVT_RX_BIT]));

  // R10
  err_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errIrq) |-> $past(wrEvt && (|busWdata[EVT_ERR_HI:EVT_ERR_LO])));

endmodule

bind dmareg_top dmareg_chk u_chk (.*);

// File: tb/sim_dmareg_top.sv
`timescale 1ns/1ps
module sim_dmareg_top;
  import dmareg_pkg::*;

  localparam logic [31:0] IDV = 32'h5E7C_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, hwEvent = '0;
  logic        busRvalid, txIrq, rxIrq, errIrq;
  logic [7:0]  txHaltIn = '0, rxHaltIn = '0;
  logic [15:0] ringKick;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #2.5 clk = ~clk;

  dmareg_top #(.IDENT_VALUE(IDV)) u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic busRd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic pulseHw(logic [31:0] ev, logic [7:0] th, logic [7:0] rh);
    @(negedge clk);
    hwEvent = ev; txHaltIn = th; rxHaltIn = rh;
    @(negedge clk);
    hwEvent = '0; txHaltIn = '0; rxHaltIn = '0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (busRvalid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R3: unexpected rvalid, got %h expected none", busRdata);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, busRdata, e);
      end
    end
  end

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 kick", 32'(ringKick), 32'h0);
    check("R1 irqs", {29'h0, txIrq, rxIrq, errIrq}, 32'h0);
    busRd(12'h000, IDV, "R1 ident");
    busRd(12'h004, 32'h0, "R1 ctrl");
    busRd(12'h008, 32'h0, "R1 event");
    busRd(12'h00C, 32'h0, "R1 txhalt");
    busRd(12'h010, 32'h0, "R1 rxhalt");
    busRd(12'h118, 32'h0, "R1 txbase3");

    // R2 / R4: byte offsets ignored, RW and RO classes
    busRd(12'h002, IDV, "R2 ident offset");
    busWr(12'h006, 32'hDEAD_BEEF);
    busRd(12'h004, 32'hDEAD_BEEF, "R2 R4 ctrl");
    busWr(12'h000, 32'h1234_5678);
    busRd(12'h000, IDV, "R4 ident ro");

    // R3: write-only and unmapped words
    busWr(12'h014, 32'h0000_1234);
    busRd(12'h014, 32'h0, "R3 cmd wo");
    busWr(12'h080, 32'hFFFF_FFFF);
    busRd(12'h080, 32'h0, "R3 unmapped");
    busWr(12'h140, 32'hFFFF_FFFF);
    busRd(12'h140, 32'h0, "R3 ring out of range");

    // R5: tx halt flags and kicks
    pulseHw(32'h0, 8'b0000_0101, 8'h0);
    busRd(12'h00C, 32'hA000_0000, "R5 tx halt set");
    busWr(12'h00C, 32'h2100_0000);
    check("R5 tx kick", 32'(ringKick), 32'h0084);
    @(negedge clk);
    check("R11 kick one cycle", 32'(ringKick), 32'h0);
    busRd(12'h00C, 32'h8000_0000, "R5 tx halt cleared");

    // R6: rx kick only for flags that were clear
    pulseHw(32'h0, 8'h0, 8'b0000_0010);
    busRd(12'h010, 32'h0040_0000, "R6 rx halt set");
    busWr(12'h010, 32'h00C0_0000);
    check("R6 rx kick selective", 32'(ringKick), 32'h0100);
    busRd(12'h010, 32'h0, "R6 rx halt cleared");
    busWr(12'h010, 32'h0040_0000);
    check("R6 rx kick now clear", 32'(ringKick), 32'h0200);

    // R7: base aligns and loads pointer
    busWr(12'h118, 32'h1000_00FF);
    busRd(12'h118, 32'h1000_00F8, "R7 tx base");
    busRd(12'h11C, 32'h1000_00F8, "R7 tx ptr copy");
    busWr(12'h11C, 32'h0000_0055);
    busRd(12'h11C, 32'h0000_0055, "R7 ptr direct");
    busRd(12'h118, 32'h1000_00F8, "R7 base kept");
    busWr(12'h238, 32'hFFFF_FFFF);
    busRd(12'h23C, 32'hFFFF_FFF8, "R7 rx ptr copy");

    // R8 / R9 / R10: events and interrupt lines
    pulseHw(32'hFFFF_FFFF, 8'h0, 8'h0);
    check("R9 R10 irqs up", {29'h0, txIrq, rxIrq, errIrq}, 32'h7);
    busRd(12'h008, 32'h00FF_FF03, "R8 event set mask");
    busWr(12'h008, 32'h0000_0001);
    check("R9 tx drop rx hold", {30'h0, txIrq, rxIrq}, 32'h1);
    busWr(12'h008, 32'h0000_0100);
    check("R10 err held", 32'(errIrq), 32'h1);
    busWr(12'h008, 32'h00FF_FE00);
    check("R10 err drop", 32'(errIrq), 32'h0);
    busRd(12'h008, 32'h0000_0002, "R8 w1c");
    busWr(12'h008, 32'h0000_0002);
    check("R9 rx drop", 32'(rxIrq), 32'h0);

    // R8: set wins over clear in the same cycle
    pulseHw(32'h1, 8'h0, 8'h0);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 12'h008; busWdata = 32'h1;
    hwEvent = 32'h1;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; hwEvent = '0;
    check("R8 R9 set wins irq", 32'(txIrq), 32'h1);
    busRd(12'h008, 32'h0000_0001, "R8 set wins");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R3: %0d reads unanswered, expected 0", expQ.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule